// File: doc/BRIEF.md
# Time-Sliced Pipeline Memory Sequencer

This block sequences a per-channel sample memory that serves as a trigger pipeline. Each clock is one half of a memory cycle, so two clocks make one memory cycle. The half-cycles alternate between two slot kinds. The acquisition slot always stores the incoming pair of 12-bit ADC words at a circular write pointer, which then advances by one pair. The access slot is the only slot in which stored data may be read. Acquisition is therefore never stalled, whatever happens on the read side.

A trigger carries a pipeline timestamp. The start address of its event is the timestamp minus a programmable latency, taken modulo the buffer depth, and it is fixed when the trigger is accepted. Accepted triggers wait in a small FIFO. A read engine takes them one at a time and fetches an 8-word event (four word pairs) from consecutive pair addresses. One pair is fetched every second memory cycle. Each pair appears on the read port with a one-clock valid strobe, and an end-of-event strobe marks the last pair. A trigger that arrives while the FIFO is full is dropped, and a sticky overflow flag records this.

Top module: `pipe_mem_seq`

## Requirements
- R1: The `slot` output is 0 (acquisition) in the first clock after reset and then toggles on every clock. Memory reads occur only in the slot-1 (access) clock.
- R2: On each clock where `slot` is 0, `adc_pair` is stored at pair address `wr_ptr`, and `wr_ptr` then advances by one, wrapping from DEPTH-1 to 0. In a slot-1 clock, `wr_ptr` holds its value.
- R3: The start address of an event is (`trig_ts` - `cfg_latency`) mod DEPTH. It is computed when the trigger is accepted, and it wraps correctly when the timestamp is smaller than the latency.
- R4: An event delivers the four stored pairs at start, start+1, start+2 and start+3 (mod DEPTH), in that order and unchanged in bit layout, so it may wrap past address DEPTH-1 to 0.
- R5: `rd_valid` is high for exactly one clock per pair, and consecutive pairs of one event are exactly 4 clocks apart (one pair per two memory cycles).
- R6: `rd_eoe` is high only together with `rd_valid`, and only on the fourth pair of an event.
- R7: Up to four accepted triggers wait while an event is being read, and their events are delivered in arrival order.
- R8: A trigger that arrives when four triggers are already waiting produces no event and sets `trig_ovf`. `trig_ovf` then stays set until reset.
- R9: While reset is held, `rd_valid`, `rd_eoe`, `rd_busy`, `trig_ovf`, `slot` and `wr_ptr` are all 0.
- R10: `rd_busy` is high from the clock after a trigger is accepted. It falls once the last pair of the last waiting event has been fetched, so it is low when that pair's `rd_eoe` is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per slot |
| rst | input | 1 | Synchronous active-high reset |
| adc_pair | input | 24 | Two ADC words, stored in the next acquisition slot |
| trig | input | 1 | Trigger request, one clock per request |
| trig_ts | input | 6 | Pipeline timestamp (pair address) of the trigger |
| cfg_latency | input | 6 | Latency subtracted from the timestamp |
| slot | output | 1 | Current slot: 0 acquisition, 1 access |
| wr_ptr | output | 6 | Circular pair address written in the next acquisition slot |
| rd_data | output | 24 | Event pair read from the pipeline |
| rd_valid | output | 1 | One-clock strobe for each delivered pair |
| rd_eoe | output | 1 | Marks the last pair of an event |
| rd_busy | output | 1 | An event is queued or being fetched |
| trig_ovf | output | 1 | Sticky flag: a trigger was lost to a full queue |

## Verification
A trigger seen at an edge enters the queue at that edge. It is taken by the idle engine one edge later. Its first pair is fetched at the next access slot that has both counter bits set, and the pair is shown one edge after the fetch, 3 to 6 clocks after the trigger. Later pairs follow every 4 clocks. The bench does not predict the exact edge of the first pair. It pushes the expected pairs into a queue at trigger time, using its own image of the memory built from the ports `slot` and `wr_ptr`, and it compares each pair whenever `rd_valid` is sampled on a falling edge. Spacing between pairs, the end-of-event flag, busy and overflow are sampled on the falling edge after the edge that updates them.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

  // Slot kind within one memory cycle
  typedef enum logic {
    SLOT_ACQ = 1'b0,
    SLOT_ACC = 1'b1
  } slot_e;

endpackage

// File: rtl/pmseq_slot_ctrl.sv
module pmseq_slot_ctrl
  import pmseq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  output slot_e         slot,
  output logic          acc_fetch,
  output logic          ram_we,
  output logic [AW-1:0] wr_ptr
);

  // seq[0] selects the slot, seq[1] marks every second memory cycle
  logic [1:0] seq;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq    <= '0;
      wr_ptr <= '0;
    end else begin
      seq <= seq + 2'd1;
      if (!seq[0]) wr_ptr <= wr_ptr + 1'b1;
    end
  end

  assign slot      = slot_e'(seq[0]);
  assign acc_fetch = (seq == 2'b11);
  assign ram_we    = !seq[0] && !rst;

  p_slot_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (slot != $past(slot)));

  p_wrptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_ACQ) |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1)));

  p_wrptr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_ACC) |=> $stable(wr_ptr));

endmodule

// File: rtl/pmseq_ram.sv
module pmseq_ram #(
  parameter int AW = 6,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first, shared by the two slots
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end

endmodule

// File: rtl/pmseq_trig_fifo.sv
module pmseq_trig_fifo #(
  parameter int DW    = 6,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          ovf
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (push && full) ovf <= 1'b1;
    end
  end

  p_drop_when_full_r8: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (cnt == $past(cnt)));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

endmodule

// File: rtl/pmseq_reader.sv
module pmseq_reader #(
  parameter int AW        = 6,
  parameter int DW        = 24,
  parameter int EVT_PAIRS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_fetch,
  input  logic          q_empty,
  input  logic [AW-1:0] q_start,
  output logic          q_pop,
  input  logic [DW-1:0] ram_q,
  output logic [AW-1:0] rd_addr,
  output logic          rd_issue,
  output logic          busy,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_eoe
);

  localparam int IW = (EVT_PAIRS > 1) ? $clog2(EVT_PAIRS) : 1;

  logic [IW-1:0] idx;
  logic          pend, pend_last, last_pair;

  assign q_pop     = !busy && !q_empty;
  assign rd_issue  = busy && acc_fetch;
  assign last_pair = (idx == IW'(EVT_PAIRS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      rd_addr   <= '0;
      idx       <= '0;
      pend      <= 1'b0;
      pend_last <= 1'b0;
      rd_valid  <= 1'b0;
      rd_eoe    <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (q_pop) begin
        busy    <= 1'b1;
        rd_addr <= q_start;
        idx     <= '0;
      end else if (rd_issue) begin
        rd_addr <= rd_addr + 1'b1;
        idx     <= idx + 1'b1;
        if (last_pair) busy <= 1'b0;
      end
      pend      <= rd_issue;
      pend_last <= rd_issue && last_pair;
      rd_valid  <= pend;
      rd_eoe    <= pend_last;
      if (pend) rd_data <= ram_q;
    end
  end

  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_eoe_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    rd_eoe |-> rd_valid);

endmodule

// File: rtl/pipe_mem_seq.sv
module pipe_mem_seq
  import pmseq_pkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int AW          = 6,
  parameter int EVT_WORDS   = 8,
  parameter int TFIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*WORD_W-1:0] adc_pair,
  input  logic                trig,
  input  logic [AW-1:0]       trig_ts,
  input  logic [AW-1:0]       cfg_latency,
  output logic                slot,
  output logic [AW-1:0]       wr_ptr,
  output logic [2*WORD_W-1:0] rd_data,
  output logic                rd_valid,
  output logic                rd_eoe,
  output logic                rd_busy,
  output logic                trig_ovf
);

  localparam int DW        = 2 * WORD_W;
  localparam int EVT_PAIRS = EVT_WORDS / 2;

  slot_e         cur_slot;
  logic          acc_fetch, ram_we, rd_issue, eng_busy;
  logic          q_pop, q_empty;
  logic [AW-1:0] q_start, rd_addr, ram_addr, trig_start;
  logic [DW-1:0] ram_q;

  pmseq_slot_ctrl #(.AW(AW)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .slot      (cur_slot),
    .acc_fetch (acc_fetch),
    .ram_we    (ram_we),
    .wr_ptr    (wr_ptr)
  );

  // start address fixed when the trigger enters the queue
  assign trig_start = trig_ts - cfg_latency;

  pmseq_trig_fifo #(.DW(AW), .DEPTH(TFIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (trig),
    .din   (trig_start),
    .pop   (q_pop),
    .dout  (q_start),
    .empty (q_empty),
    .ovf   (trig_ovf)
  );

  assign ram_addr = (cur_slot == SLOT_ACQ) ? wr_ptr : rd_addr;

  pmseq_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (adc_pair),
    .q     (ram_q)
  );

  pmseq_reader #(.AW(AW), .DW(DW), .EVT_PAIRS(EVT_PAIRS)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .acc_fetch (acc_fetch),
    .q_empty   (q_empty),
    .q_start   (q_start),
    .q_pop     (q_pop),
    .ram_q     (ram_q),
    .rd_addr   (rd_addr),
    .rd_issue  (rd_issue),
    .busy      (eng_busy),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_eoe    (rd_eoe)
  );

  assign slot    = (cur_slot == SLOT_ACC);
  assign rd_busy = eng_busy || !q_empty;

  p_slot_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && rd_issue));

  p_ovf_needs_trig_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_ovf) |-> $past(trig));

endmodule

// File: tb/pipe_mem_seq_bench.sv
`timescale 1ns/1ps
module pipe_mem_seq_bench;

  localparam int WW    = 12;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = 2 * WW;

  logic          clk = 1'b0;
  logic          rst;
  logic [PW-1:0] adc_pair;
  logic          trig;
  logic [AW-1:0] trig_ts, cfg_latency;
  logic          slot, rd_valid, rd_eoe, rd_busy, trig_ovf;
  logic [AW-1:0] wr_ptr;
  logic [PW-1:0] rd_data;

  always #2.5 clk = ~clk;

  pipe_mem_seq u_pipe_mem_seq (
    .clk(clk), .rst(rst), .adc_pair(adc_pair), .trig(trig), .trig_ts(trig_ts),
    .cfg_latency(cfg_latency), .slot(slot), .wr_ptr(wr_ptr), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_eoe(rd_eoe), .rd_busy(rd_busy), .trig_ovf(trig_ovf)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [PW-1:0] model [DEPTH];
  logic [PW-1:0] exp_q[$];
  bit            exp_last[$];
  int adc_n = 0;
  int cyc = 0, last_v = 0;
  bit mid_evt = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // ADC driver and memory image built from slot and wr_ptr (R2)
  always @(negedge clk) begin
    adc_n++;
    adc_pair = {WW'(adc_n * 5 + 3), WW'(adc_n * 11 + 1)};
    if (!rst && slot == 1'b0) model[wr_ptr] = adc_pair;
  end

  // monitor: pops expected pairs as the design delivers them
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      if (rd_eoe && !rd_valid) chk("R6 eoe without valid", 1, 0);
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          chk("R8 unexpected pair", 1, 0);
        end else begin
          chk("R4 R7 pair data", rd_data, exp_q.pop_front());
          chk("R6 end flag", rd_eoe, exp_last.pop_front());
          if (mid_evt) chk("R5 pair spacing", cyc - last_v, 4);
          last_v  = cyc;
          mid_evt = !rd_eoe;
          if (rd_eoe && exp_q.size() == 0) chk("R10 busy low at last eoe", rd_busy, 0);
        end
      end
    end
  end

  task automatic send_trig(logic [AW-1:0] ts, logic [AW-1:0] lat, bit accept);
    logic [AW-1:0] st;
    @(negedge clk);
    trig = 1'b1;
    trig_ts = ts;
    cfg_latency = lat;
    st = ts - lat;
    if (accept) begin
      for (int k = 0; k < 4; k++) begin
        exp_q.push_back(model[AW'(st + AW'(k))]);
        exp_last.push_back(k == 3);
      end
    end
  endtask

  task automatic trig_off();
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_ptr(logic [AW-1:0] p);
    while (wr_ptr != p) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] p_ptr;
    logic          p_sl;
    rst = 1'b1;
    trig = 1'b0;
    trig_ts = '0;
    cfg_latency = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 rd_valid", rd_valid, 0);
    chk("R9 rd_eoe", rd_eoe, 0);
    chk("R9 rd_busy", rd_busy, 0);
    chk("R9 trig_ovf", trig_ovf, 0);
    chk("R9 slot", slot, 0);
    chk("R9 wr_ptr", wr_ptr, 0);
    @(posedge clk);
    #1 rst = 1'b0;

    // pointer and slot sequencing across the wrap
    @(negedge clk);
    chk("R1 first slot", slot, 0);
    wait_ptr(AW'(DEPTH - 2));
    for (int i = 0; i < 8; i++) begin
      p_ptr = wr_ptr;
      p_sl  = slot;
      @(negedge clk);
      chk("R1 slot toggles", slot, !p_sl);
      chk("R2 write pointer", wr_ptr, p_sl ? p_ptr : AW'(p_ptr + 1'b1));
    end
    repeat (140) @(negedge clk);

    // single event
    send_trig(wr_ptr, 6, 1'b1);
    trig_off();
    chk("R10 busy after trigger", rd_busy, 1);
    drain();

    // timestamp below latency: start wraps to 60
    wait_ptr(2);
    send_trig(2, 6, 1'b1);
    trig_off();
    drain();

    // event crossing the top of the buffer: 62,63,0,1
    wait_ptr(4);
    send_trig(4, 6, 1'b1);
    trig_off();
    drain();

    // other latency value (R3)
    send_trig(AW'(wr_ptr + 3), 9, 1'b1);
    trig_off();
    drain();

    // burst: one in service, four queued, sixth dropped
    chk("R8 ovf clear before burst", trig_ovf, 0);
    for (int i = 0; i < 6; i++) send_trig(wr_ptr, AW'(5 + i), i < 5);
    trig_off();
    chk("R8 ovf set on full queue", trig_ovf, 1);
    drain();
    chk("R8 ovf sticky", trig_ovf, 1);
    chk("R10 busy idle after drain", rd_busy, 0);
    chk("R7 queue empty after drain", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule